// File: doc/BRIEF.md
# Line-Period Sync Timer

This block is a free-running line timer with a bank of compare channels that shape video sync waveforms. An up-counter runs from zero to a programmed period value, returns to zero on the next cycle and, each time it does, sets a sticky line flag. The flag can be routed to an interrupt line through an enable bit.

Each compare channel watches the shared count and drives one output pin. Its behaviour is chosen by a three-bit mode code. The pulse mode gives a two-edge waveform that repeats on every line, which suits horizontal sync. The two single-edge modes drive the pin low or high once when the count matches, and keep that level. Software re-arms the channel between frames, which suits vertical sync.

Software reaches every setting through a single-cycle write port. Each channel also has an enable pin.

Top module: `line_sync_timer`

## Requirements
- R1: While running (control bit 0 set), the count steps by one per clock from 0 to the period value, then reads 0 on the following cycle, so a line lasts period+1 cycles.
- R2: The cycle in which the count leaves the period value sets `line_flag`. The flag stays set until a control write has bit 2 set. A set and a clear in the same cycle leave the flag set. `line_irq` is `line_flag` AND control bit 1, and the flag sets even while bit 1 is clear.
- R3: Mode 3'b101 (mode register bits [2:0]) is the pulse mode. One cycle after the count equals the primary compare, the output goes high. One cycle after the count equals the secondary compare, it goes low. This repeats on every line.
- R4: A primary compare holding the pulse end and a secondary compare holding the pulse start give a low-going pulse. Swapping the two values gives a high-going pulse.
- R5: Mode 3'b010, when armed, drives the output low one cycle after the count equals the primary compare.
- R6: Mode 3'b001, when armed, drives the output high one cycle after the count equals the primary compare. A compare of 0 takes effect at the start of the next line.
- R7: A single-edge mode disarms after its match and holds the level over later lines. Writing the mode register while the channel is enabled re-arms it, and so does enabling the channel.
- R8: A disabled channel drives low from the next cycle. All outputs are low after reset.
- R9: Clearing control bit 0 freezes the count. Setting it again resumes from the frozen value without clearing the count or the flag.
- R10: Mode codes other than 3'b101, 3'b010 and 3'b001 hold the output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | AW | 0 control, 1 period, then per channel i: 2+3i mode, 3+3i primary, 4+3i secondary |
| wr_data | input | CNT_W | write data |
| chan_en | input | NUM_CH | per-channel enable |
| sync_out | output | NUM_CH | compare outputs |
| line_flag | output | 1 | sticky line-wrap flag |
| line_irq | output | 1 | flag gated by interrupt enable |

## Verification
Several rules are checked by assertions on every cycle:
- the return to zero after the period value;
- the flag holding until it is cleared;
- the frozen count while stopped;
- the forced-low output of a disabled channel;
- the edge a matched pulse or single-edge channel must produce.

Other behaviour appears only across whole scenarios, so only the bench's scenarios can show it:
- the exact line length;
- which polarity results from a given ordering of the compare values;
- the one-shot hold across several lines and the re-arm by a mode write;
- a compare of zero taking effect at the next line;
- the resume point after a stop.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
   localparam logic [2:0] MODE_PULSE  = 3'b101;
   localparam logic [2:0] MODE_SET_LO = 3'b010;
   localparam logic [2:0] MODE_SET_HI = 3'b001;
   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_IRQ_BIT = 1;
   localparam int CTRL_CLR_BIT = 2;
   localparam int REGS_PER_CH  = 3;
   localparam int CH_BASE      = 2;
endpackage

// File: rtl/lsync_timebase.sv
module lsync_timebase
   import lsync_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt,
   output logic             flag,
   output logic             irq
);
   logic             run_q;
   logic             irq_en_q;
   logic [CNT_W-1:0] period_q;
   logic             wrap;
   logic             clr;

   assign wrap = run_q && (cnt == period_q);
   assign clr  = wr_ctrl && wr_data[CTRL_CLR_BIT];
   assign irq  = flag && irq_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         irq_en_q <= 1'b0;
         period_q <= '1;
      end else begin
         if (wr_ctrl) begin
            run_q    <= wr_data[CTRL_RUN_BIT];
            irq_en_q <= wr_data[CTRL_IRQ_BIT];
         end
         if (wr_period) period_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (wrap)       cnt <= '0;
         else if (run_q) cnt <= cnt + 1'b1;
         if (wrap)       flag <= 1'b1;
         else if (clr)   flag <= 1'b0;
      end
   end

   // R1
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt == period_q) |=> (cnt == '0 && flag));
   // R2
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   // R9
   frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> $stable(cnt));
endmodule

// File: rtl/lsync_cmp_chan.sv
module lsync_cmp_chan
   import lsync_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr_mode,
   input  logic             wr_pri,
   input  logic             wr_sec,
   input  logic [CNT_W-1:0] wr_data,
   output logic             out
);
   logic [2:0]       mode_q;
   logic [CNT_W-1:0] pri_q;
   logic [CNT_W-1:0] sec_q;
   logic             armed;
   logic             hit_pri;
   logic             hit_sec;

   assign hit_pri = (cnt == pri_q);
   assign hit_sec = (cnt == sec_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pri_q  <= '0;
         sec_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= wr_data[2:0];
         if (wr_pri)  pri_q  <= wr_data;
         if (wr_sec)  sec_q  <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out   <= 1'b0;
         armed <= 1'b1;
      end else if (!en) begin
         out   <= 1'b0;
         armed <= 1'b1;
      end else begin
         case (mode_q)
            MODE_PULSE: begin
               if (hit_pri)      out <= 1'b1;
               else if (hit_sec) out <= 1'b0;
            end
            MODE_SET_LO: if (armed && hit_pri) begin
               out   <= 1'b0;
               armed <= 1'b0;
            end
            MODE_SET_HI: if (armed && hit_pri) begin
               out   <= 1'b1;
               armed <= 1'b0;
            end
            default: out <= out;
         endcase
         if (wr_mode) armed <= 1'b1;
      end
   end

   // R8
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !out);
   // R3
   pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode_q == MODE_PULSE && hit_pri) |=> out);
   // R5
   set_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode_q == MODE_SET_LO && armed && hit_pri) |=> !out);
   // R6
   set_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode_q == MODE_SET_HI && armed && hit_pri) |=> out);
endmodule

// File: rtl/line_sync_timer.sv
module line_sync_timer
   import lsync_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2,
   localparam int NREGS = CH_BASE + REGS_PER_CH * NUM_CH,
   localparam int AW    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [NUM_CH-1:0] chan_en,
   output logic [NUM_CH-1:0] sync_out,
   output logic              line_flag,
   output logic              line_irq
);
   logic [CNT_W-1:0] cnt;

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("CNT_W must be at least 4");
      end
      if (NUM_CH < 1) begin : g_bad_count
         $error("NUM_CH must be at least 1");
      end
   endgenerate

   lsync_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_en && wr_addr == AW'(0)),
      .wr_period (wr_en && wr_addr == AW'(1)),
      .wr_data   (wr_data),
      .cnt       (cnt),
      .flag      (line_flag),
      .irq       (line_irq)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int BASE = CH_BASE + REGS_PER_CH * i;
      lsync_cmp_chan #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (chan_en[i]),
         .cnt     (cnt),
         .wr_mode (wr_en && wr_addr == AW'(BASE)),
         .wr_pri  (wr_en && wr_addr == AW'(BASE + 1)),
         .wr_sec  (wr_en && wr_addr == AW'(BASE + 2)),
         .wr_data (wr_data),
         .out     (sync_out[i])
      );
   end
endmodule

// File: tb/line_sync_timer_tb.sv
module line_sync_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int P = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  chan_en = '0;
   logic [1:0]  sync_out;
   logic        line_flag;
   logic        line_irq;

   int checks = 0;
   int fails = 0;
   int k = 0;
   int cyc = 0;
   int ctrl_bits = 0;
   bit done = 0;

   line_sync_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .chan_en(chan_en), .sync_out(sync_out),
      .line_flag(line_flag), .line_irq(line_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
         report();
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
      end
   endtask

   task automatic step();
      @(negedge clk);
      k++;
   endtask

   task automatic upto(input int t);
      while (k < t) step();
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
      step();
      wr_en = 1'b0;
   endtask

   task automatic sync_line();
      wr(0, ctrl_bits | 4);
      while (!line_flag) step();
      k = 0;
   endtask

   task automatic t_reset();
      chk("R8 reset out", int'(sync_out), 0);
      chk("R2 reset flag", int'(line_flag), 0);
      chk("R2 reset irq", int'(line_irq), 0);
   endtask

   task automatic t_period();
      int n;
      sync_line();
      wr(0, ctrl_bits | 4);
      n = 1;
      while (!line_flag) begin step(); n++; end
      chk("R1 line length", n, P + 1);
   endtask

   task automatic t_flag();
      sync_line();
      upto(5);
      chk("R2 flag sticky", int'(line_flag), 1);
      chk("R2 irq gated off", int'(line_irq), 0);
      sync_line();
      ctrl_bits = 3;
      wr(0, ctrl_bits);
      chk("R2 irq on", int'(line_irq), 1);
      wr(0, ctrl_bits | 4);
      chk("R2 flag cleared", int'(line_flag), 0);
      chk("R2 irq cleared", int'(line_irq), 0);
      upto(9);
      wr(0, ctrl_bits | 4);
      chk("R2 set beats clear", int'(line_flag), 1);
      ctrl_bits = 1;
      wr(0, ctrl_bits);
   endtask

   task automatic t_stop();
      int n;
      sync_line();
      wr(0, 4);
      repeat (20) step();
      chk("R9 frozen no wrap", int'(line_flag), 0);
      wr(0, 1);
      n = 0;
      while (!line_flag) begin step(); n++; end
      chk("R9 resume point", n, P);
   endtask

   task automatic t_pulse_neg();
      wr(3, 6); wr(4, 2); wr(2, 3'b101);
      chan_en[0] = 1'b1;
      sync_line(); sync_line();
      chk("R3 high from prev line", int'(sync_out[0]), 1);
      upto(2); chk("R4 neg before start", int'(sync_out[0]), 1);
      upto(3); chk("R4 neg low at start", int'(sync_out[0]), 0);
      upto(6); chk("R3 still low", int'(sync_out[0]), 0);
      upto(7); chk("R3 rise at end", int'(sync_out[0]), 1);
   endtask

   task automatic t_pulse_pos();
      wr(3, 2); wr(4, 6);
      sync_line(); sync_line();
      upto(2); chk("R4 pos low before", int'(sync_out[0]), 0);
      upto(3); chk("R4 pos high", int'(sync_out[0]), 1);
      upto(6); chk("R4 pos still high", int'(sync_out[0]), 1);
      upto(7); chk("R4 pos low after", int'(sync_out[0]), 0);
      sync_line();
      upto(4);
      chan_en[0] = 1'b0;
      step();
      chk("R8 disabled low", int'(sync_out[0]), 0);
      sync_line(); upto(4);
      chk("R8 stays low", int'(sync_out[0]), 0);
   endtask

   task automatic t_single();
      chan_en[1] = 1'b1;
      wr(6, 0);
      sync_line();
      wr(5, 3'b001);
      sync_line();
      chk("R6 before line start", int'(sync_out[1]), 0);
      step();
      chk("R6 zero compare high", int'(sync_out[1]), 1);
      wr(6, 4);
      wr(5, 3'b010);
      upto(4); chk("R5 before match", int'(sync_out[1]), 1);
      upto(5); chk("R5 low at match", int'(sync_out[1]), 0);
      sync_line(); upto(8);
      chk("R7 level held", int'(sync_out[1]), 0);
      wr(5, 3'b001);
      sync_line();
      upto(4); chk("R7 rearm before", int'(sync_out[1]), 0);
      upto(5); chk("R7 rearm by mode", int'(sync_out[1]), 1);
      wr(5, 3'b000);
      wr(6, 1);
      sync_line(); sync_line(); upto(8);
      chk("R10 hold mode", int'(sync_out[1]), 1);
      wr(6, 4); wr(5, 3'b010);
      sync_line(); upto(6);
      chk("R5 low again", int'(sync_out[1]), 0);
      chan_en[1] = 1'b0;
      step();
      wr(5, 3'b001);
      chan_en[1] = 1'b1;
      sync_line(); upto(5);
      chk("R7 rearm by enable", int'(sync_out[1]), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      wr(1, P);
      ctrl_bits = 1;
      wr(0, ctrl_bits);
      t_period();
      t_flag();
      t_stop();
      t_pulse_neg();
      t_pulse_pos();
      t_single();
      done = 1;
      report();
   end
endmodule